// File: doc/BRIEF.md
# Control-Free Stochastic Bitstream Adder

This block adds two unipolar stochastic bitstreams and produces the scaled sum (a+b)/2, one bit per clock. In a unipolar stream a value is the probability of a 1, and every bit carries the same weight. The classic adder for such streams is a 2:1 multiplexer whose select line is a random stream. That select stream is a second source of error over a finite stream.

This adder needs no select stream. An XOR flags the cycles where the two input bits disagree. A two-state toggle machine then decides which of the two inputs wins on each disagreement, alternating between them. When the bits agree, the common bit passes straight through. Over any run, exactly half of the disagreeing bits come out as 1. The output count therefore always lies within half a bit of the exact scaled sum.

A `MODE` parameter selects the multiplexer adder instead, driven by the external `sel` input, so the two adders can be compared directly. The toggle machine has two states. TGL_LOW means the next disagreement emits 0, and TGL_HIGH means it emits 1. The transition TGL_LOW to TGL_HIGH and the transition TGL_HIGH to TGL_LOW both happen only on a valid disagreeing cycle. All other cycles hold the state.

Top module: `sc_pair_adder`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) forces `y` to 0 and puts the toggle machine in TGL_LOW, so the first valid disagreement after reset emits 0.
- R2: In toggle mode, a valid cycle with `a` equal to `b` makes `y` equal that common bit.
- R3: In toggle mode, a valid cycle with `a` different from `b` makes `y` equal the current toggle state (TGL_LOW gives 0, TGL_HIGH gives 1), and the state then flips. Successive disagreements emit 0, 1, 0, 1 and so on.
- R4: A valid cycle where `a` equals `b` leaves the toggle state unchanged.
- R5: A cycle with `valid` low changes neither `y` nor the toggle state.
- R6: Over N valid cycles after reset in toggle mode, the number of 1s on `y` equals floor((count_a + count_b)/2).
- R7: In multiplexer mode, a valid cycle gives `y` = `b` when `sel` is 1 and `y` = `a` when `sel` is 0.
- R8: `y` is registered. The inputs of a valid cycle appear on `y` after the next rising clock edge, and not before it.
- R9: Over the same set of 256-bit streams, the toggle mode's total absolute error against (count_a + count_b)/2 is smaller than the multiplexer mode's total error.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| valid | input | 1 | Marks a cycle that carries a bit pair |
| a | input | 1 | First input stream bit |
| b | input | 1 | Second input stream bit |
| sel | input | 1 | Select bit, read only in multiplexer mode |
| y | output | 1 | Registered sum stream bit |

## Verification
The hardest case to reach is a toggle state that survives cycles that should not move it. The state must hold across agreeing cycles and across cycles with `valid` low, while the disagreeing inputs are still on the pins. The only way to see the state is through `y` on a later disagreement. The directed sequence therefore mixes disagreements with agreeing cycles and idle cycles, and checks the parity of the next emitted bit. It also resets the block while the state is TGL_HIGH. LFSR-driven comparators produce streams at eight pairs of probabilities, which exercise the count bound and the error comparison between the two modes.

// File: rtl/sc_add_pkg.sv
package sc_add_pkg;

    typedef enum logic {
        ADD_TOGGLE = 1'b0,
        ADD_MUX    = 1'b1
    } add_mode_e;

    typedef enum logic {
        TGL_LOW  = 1'b0,
        TGL_HIGH = 1'b1
    } tgl_state_e;

endpackage

// File: rtl/sc_mismatch_detect.sv
module sc_mismatch_detect (
    input  logic a,
    input  logic b,
    output logic diff
);
    always_comb diff = a ^ b;
endmodule

// File: rtl/sc_toggle_fsm.sv
module sc_toggle_fsm
    import sc_add_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic valid,
    input  logic diff,
    output logic phase
);
    tgl_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (rst) state_q <= TGL_LOW;
        else     state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TGL_LOW:  if (valid && diff) state_d = TGL_HIGH;
            TGL_HIGH: if (valid && diff) state_d = TGL_LOW;
            default:  state_d = TGL_LOW;
        endcase
    end

    always_comb phase = (state_q == TGL_HIGH);

    assert_idle_holds_state_R5: assert property (@(posedge clk) disable iff (rst)
        !valid |=> $stable(phase));
    assert_agree_holds_state_R4: assert property (@(posedge clk) disable iff (rst)
        (valid && !diff) |=> $stable(phase));
    assert_disagree_flips_R3: assert property (@(posedge clk) disable iff (rst)
        (valid && diff) |=> (phase != $past(phase)));
    assert_reset_low_R1: assert property (@(posedge clk)
        rst |=> !phase);
endmodule

// File: rtl/sc_out_stage.sv
module sc_out_stage
    import sc_add_pkg::*;
#(
    parameter add_mode_e MODE = ADD_TOGGLE
) (
    input  logic clk,
    input  logic rst,
    input  logic valid,
    input  logic a,
    input  logic b,
    input  logic sel,
    input  logic diff,
    input  logic phase,
    output logic y
);
    logic y_d, y_q;

    always_comb begin
        if (MODE == ADD_MUX) y_d = sel ? b : a;
        else                 y_d = diff ? phase : a;
    end

    always_ff @(posedge clk) begin
        if (rst)        y_q <= 1'b0;
        else if (valid) y_q <= y_d;
    end

    always_comb y = y_q;

    assert_reset_clears_y_R1: assert property (@(posedge clk)
        rst |=> !y);
    assert_idle_holds_y_R5: assert property (@(posedge clk) disable iff (rst)
        !valid |=> $stable(y));
    assert_agree_passes_R2: assert property (@(posedge clk) disable iff (rst)
        (MODE == ADD_TOGGLE && valid && (a == b)) |=> (y == $past(a)));
    assert_disagree_uses_phase_R3: assert property (@(posedge clk) disable iff (rst)
        (MODE == ADD_TOGGLE && valid && diff) |=> (y == $past(phase)));
    assert_mux_select_R7: assert property (@(posedge clk) disable iff (rst)
        (MODE == ADD_MUX && valid && sel) |=> (y == $past(b)));
endmodule

// File: rtl/sc_pair_adder.sv
module sc_pair_adder
    import sc_add_pkg::*;
#(
    parameter add_mode_e MODE = ADD_TOGGLE
) (
    input  logic clk,
    input  logic rst,
    input  logic valid,
    input  logic a,
    input  logic b,
    input  logic sel,
    output logic y
);
    logic diff;
    logic phase;

    sc_mismatch_detect u_detect (
        .a    (a),
        .b    (b),
        .diff (diff)
    );

    generate
        if (MODE == ADD_TOGGLE) begin : g_toggle
            sc_toggle_fsm u_fsm (
                .clk   (clk),
                .rst   (rst),
                .valid (valid),
                .diff  (diff),
                .phase (phase)
            );
        end else begin : g_mux
            assign phase = 1'b0;
        end
    endgenerate

    sc_out_stage #(.MODE(MODE)) u_out (
        .clk   (clk),
        .rst   (rst),
        .valid (valid),
        .a     (a),
        .b     (b),
        .sel   (sel),
        .diff  (diff),
        .phase (phase),
        .y     (y)
    );
endmodule

// File: tb/tb_sc_pair_adder.sv
module tb_sc_pair_adder;
    import sc_add_pkg::*;

    localparam int STREAM_LEN = 256;
    localparam int NPAIR      = 8;
    // each entry: {probability of a, probability of b}, out of 256
    localparam logic [15:0] PAIRS [NPAIR] = '{
        16'h40_80, 16'h10_F0, 16'hC0_C0, 16'h20_30,
        16'hE0_08, 16'h80_80, 16'h55_AA, 16'h01_FE
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic valid = 1'b0;
    logic a = 1'b0, b = 1'b0, sel = 1'b0;
    logic y, y_mux;
    int   total = 0, bad = 0;
    bit   done = 1'b0;

    always #2.5 clk = ~clk;

    sc_pair_adder #(.MODE(ADD_TOGGLE)) dut (
        .clk(clk), .rst(rst), .valid(valid), .a(a), .b(b), .sel(sel), .y(y));
    sc_pair_adder #(.MODE(ADD_MUX)) dut_mux (
        .clk(clk), .rst(rst), .valid(valid), .a(a), .b(b), .sel(sel), .y(y_mux));

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step(input logic va, input logic vb, input logic vs, input logic vv);
        @(negedge clk);
        a = va; b = vb; sel = vs; valid = vv;
        @(posedge clk);
        #1;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; valid = 1'b0;
        @(posedge clk);
        #1;
        @(negedge clk);
        rst = 1'b0;
    endtask

    function automatic logic [15:0] lfsr_next(input logic [15:0] s);
        return s[0] ? ((s >> 1) ^ 16'hB400) : (s >> 1);
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [15:0] la, lb, ls;
        int cf_err2_sum, mux_err2_sum;
        la = 16'hACE1; lb = 16'h1D37; ls = 16'h7B2F;
        cf_err2_sum = 0; mux_err2_sum = 0;

        // R1: reset state
        @(posedge clk); #1;
        check("R1 y after reset", y, 0);
        do_reset();

        // R1/R3/R2/R4: directed toggle sequence
        step(1, 0, 0, 1); check("R1 R3 first disagreement emits 0", y, 0);
        step(1, 1, 0, 1); check("R2 agree on 1", y, 1);
        step(0, 0, 0, 1); check("R2 agree on 0", y, 0);
        step(0, 1, 0, 1); check("R3 R4 second disagreement emits 1", y, 1);
        // R5: idle with disagreeing pins must not move y or state
        step(1, 0, 0, 0); check("R5 y held while idle", y, 1);
        step(0, 0, 0, 0); check("R5 y held while idle, agree pins", y, 1);
        step(1, 0, 0, 1); check("R5 R3 state held across idle", y, 0);
        // R8: output stays until edge
        @(negedge clk);
        a = 1; b = 1; valid = 1;
        #1; check("R8 no change before edge", y, 0);
        @(posedge clk); #1;
        check("R8 change after edge", y, 1);
        // state now TGL_HIGH; reset mid-run must restore TGL_LOW (R1)
        do_reset();
        #1; check("R1 y cleared by mid reset", y, 0);
        step(0, 1, 0, 1); check("R1 disagreement after mid reset emits 0", y, 0);

        // R7: multiplexer mode directed
        do_reset();
        step(0, 1, 1, 1); check("R7 sel=1 picks b", y_mux, 1);
        step(0, 1, 0, 1); check("R7 sel=0 picks a", y_mux, 0);
        step(1, 0, 0, 1); check("R7 sel=0 picks a (1)", y_mux, 1);

        // Table walk: R6, R7, R9 over 256-bit streams
        for (int p = 0; p < NPAIR; p++) begin
            int ca, cb, ones_cf, ones_mux, e_cf, e_mux;
            logic model_phase;
            ca = 0; cb = 0; ones_cf = 0; ones_mux = 0;
            model_phase = 1'b0;
            do_reset();
            for (int i = 0; i < STREAM_LEN; i++) begin
                logic ba, bb, bs, exp_cf;
                la = lfsr_next(la); lb = lfsr_next(lb); ls = lfsr_next(ls);
                ba = (la[7:0] < PAIRS[p][15:8]);
                bb = (lb[7:0] < PAIRS[p][7:0]);
                bs = ls[0];
                step(ba, bb, bs, 1);
                ca += int'(ba); cb += int'(bb);
                if (ba == bb) exp_cf = ba;
                else begin exp_cf = model_phase; model_phase = ~model_phase; end
                if (y != exp_cf) check("R3 R2 stream bit", y, exp_cf);
                if (y_mux != (bs ? bb : ba)) check("R7 stream bit", y_mux, bs ? bb : ba);
                ones_cf += int'(y); ones_mux += int'(y_mux);
            end
            check("R6 ones count floor bound", ones_cf, (ca + cb) / 2);
            e_cf  = 2 * ones_cf - (ca + cb);  if (e_cf < 0) e_cf = -e_cf;
            e_mux = 2 * ones_mux - (ca + cb); if (e_mux < 0) e_mux = -e_mux;
            cf_err2_sum += e_cf; mux_err2_sum += e_mux;
        end
        $display("mean abs error (bits): toggle=%0f mux=%0f",
                 real'(cf_err2_sum) / (2.0 * NPAIR), real'(mux_err2_sum) / (2.0 * NPAIR));
        check("R9 toggle error below mux error", int'(cf_err2_sum < mux_err2_sum), 1);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule